// File: doc/BRIEF.md
# Packet Character FIFO

A single-clock first-in first-out buffer for packet characters. Each character is nine bits wide: a marker bit and a byte. With the marker bit low the byte is ordinary payload. With the marker bit high the byte names an end-of-packet marker: 0x00 closes the packet normally and 0x01 closes it with an error. A producer offers a character with a write strobe and watches a ready signal. A consumer sees a valid signal together with the oldest character and takes that character with a read strobe.

The read side is first-word-fall-through. A character written in one cycle shows on the read outputs after the next clock edge, with no further read latency. Both sides have a half-full flag for flow control. The read side also decodes the head character into a normal-end and an error-end indication. Depth is 2^ADDR_W entries, with ADDR_W = 11 by default.

Top module: `pkt_char_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer. During and right after reset, rd_valid is low, wr_ready is high, and both half-full outputs are low.
- R2: A character is stored only on a rising edge where wr_en and wr_ready are both high. A write strobe while wr_ready is low leaves the contents unchanged.
- R3: wr_ready is high when the buffer holds fewer than DEPTH characters. When the buffer is full, wr_ready is high only while rd_en is high in the same cycle.
- R4: rd_valid is high exactly when the buffer is not empty. rd_marker and rd_byte then show the oldest stored character. A write to an empty buffer appears at the read side one edge later.
- R5: On a rising edge where rd_en and rd_valid are both high, the head character is removed and the next one is presented. A read strobe while rd_valid is low has no effect.
- R6: wr_half and rd_half are both high exactly when occupancy is at least DEPTH/2.
- R7: An accepted write and an accepted read on the same edge leave occupancy unchanged. This includes a full buffer, where the write goes into the slot the read frees.
- R8: rd_end_normal is high when rd_valid is high, rd_marker is 1 and rd_byte is 0x00. rd_end_error is high when rd_valid is high, rd_marker is 1 and rd_byte is 0x01. Both are low for payload (marker 0) and for any other marked byte.
- R9: Characters leave in the order they were accepted, across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe from the producer |
| wr_marker | input | 1 | Marker bit of the character being written |
| wr_byte | input | 8 | Byte of the character being written |
| wr_ready | output | 1 | Buffer can accept a character this cycle |
| wr_half | output | 1 | Occupancy is at least half the depth (write side) |
| rd_valid | output | 1 | A character is presented on the read side |
| rd_marker | output | 1 | Marker bit of the head character |
| rd_byte | output | 8 | Byte of the head character |
| rd_en | input | 1 | Read strobe from the consumer |
| rd_half | output | 1 | Occupancy is at least half the depth (read side) |
| rd_end_normal | output | 1 | Head character is a normal end-of-packet marker |
| rd_end_error | output | 1 | Head character is an error end-of-packet marker |

## Verification
The embedded properties check a set of rules on every cycle. A full buffer with no read never moves its write pointer. An empty buffer never moves its read pointer. A simultaneous write and read keeps occupancy fixed. A lone write always makes the read side valid. The two end indications are never both high. Data ordering, correct head contents after pointer wrap, the exact half-full threshold, and the byte decode of each marker kind can only be shown by the scenarios. A reference occupancy model and an expected-character queue in the bench track those across filling, overfilling, draining, and long streams with mixed strobes.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    typedef struct packed {
        logic       marker;
        logic [7:0] byte_val;
    } pkt_char_t;

    typedef enum logic [1:0] {
        KIND_PAYLOAD = 2'd0,
        KIND_END_OK  = 2'd1,
        KIND_END_BAD = 2'd2,
        KIND_OTHER   = 2'd3
    } pkt_kind_e;

    localparam logic [7:0] END_OK_CODE  = 8'h00;
    localparam logic [7:0] END_BAD_CODE = 8'h01;

    function automatic pkt_kind_e classify(input pkt_char_t c);
        if (!c.marker)                     return KIND_PAYLOAD;
        else if (c.byte_val == END_OK_CODE)  return KIND_END_OK;
        else if (c.byte_val == END_BAD_CODE) return KIND_END_BAD;
        else                               return KIND_OTHER;
    endfunction

endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store
    import pkt_fifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  pkt_char_t         wdata,
    input  logic [ADDR_W-1:0] raddr,
    output pkt_char_t         rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    pkt_char_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // combinational read gives first-word-fall-through
    assign rdata = mem[raddr];

endmodule

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              not_empty,
    output logic              can_accept,
    output logic              half
);
    localparam int          DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0] HALF_CNT = (ADDR_W+1)'(DEPTH / 2);

    logic [ADDR_W:0] count;
    logic            full;

    assign full       = (count == FULL_CNT);
    assign not_empty  = (count != '0);
    assign pop        = rd_req && not_empty;
    assign can_accept = !full || pop;
    assign push       = wr_req && can_accept;
    assign half       = (count >= HALF_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            wr_addr <= '0;
            rd_addr <= '0;
        end else begin
            if (push) wr_addr <= wr_addr + 1'b1;
            if (pop)  rd_addr <= rd_addr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_req) |=> (full && $stable(wr_addr))); // R3
    AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!not_empty) |=> $stable(rd_addr)); // R5
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(count)); // R7
    AST_PUSH_MAKES_VALID: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> not_empty); // R4

endmodule

// File: rtl/pkt_char_fifo.sv
module pkt_char_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_marker,
    input  logic [7:0] wr_byte,
    output logic       wr_ready,
    output logic       wr_half,
    output logic       rd_valid,
    output logic       rd_marker,
    output logic [7:0] rd_byte,
    input  logic       rd_en,
    output logic       rd_half,
    output logic       rd_end_normal,
    output logic       rd_end_error
);
    logic              push, pop, half;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    pkt_char_t         in_char, head;
    pkt_kind_e         head_kind;

    assign in_char = '{marker: wr_marker, byte_val: wr_byte};

    pkt_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_en),
        .rd_req     (rd_en),
        .push       (push),
        .pop        (pop),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .not_empty  (rd_valid),
        .can_accept (wr_ready),
        .half       (half)
    );

    pkt_fifo_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_addr),
        .wdata (in_char),
        .raddr (rd_addr),
        .rdata (head)
    );

    assign head_kind     = classify(head);
    assign rd_marker     = head.marker;
    assign rd_byte       = head.byte_val;
    assign rd_end_normal = rd_valid && (head_kind == KIND_END_OK);
    assign rd_end_error  = rd_valid && (head_kind == KIND_END_BAD);
    assign wr_half       = half;
    assign rd_half       = half;

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_end_normal, rd_end_error})); // R8
    AST_END_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (rd_end_normal || rd_end_error) |-> (rd_valid && rd_marker)); // R8
    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        pop |-> rd_valid); // R5

endmodule

// File: tb/test_pkt_char_fifo.sv
module test_pkt_char_fifo;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_marker = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       wr_ready, wr_half, rd_valid, rd_marker, rd_half;
    logic [7:0] rd_byte;
    logic       rd_end_normal, rd_end_error;

    int errors = 0;
    int checks = 0;
    int model_cnt = 0;
    bit done = 0;
    logic [8:0] expq[$];

    always #10 clk = ~clk;

    pkt_char_fifo #(.ADDR_W(AW)) i_pkt_char_fifo (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_marker(wr_marker), .wr_byte(wr_byte),
        .wr_ready(wr_ready), .wr_half(wr_half),
        .rd_valid(rd_valid), .rd_marker(rd_marker), .rd_byte(rd_byte),
        .rd_en(rd_en), .rd_half(rd_half),
        .rd_end_normal(rd_end_normal), .rd_end_error(rd_end_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus, applied just after the rising edge
    task automatic cyc(input bit w, input bit m, input logic [7:0] b, input bit r);
        @(posedge clk);
        #1;
        wr_en = w; wr_marker = m; wr_byte = b; rd_en = r;
    endtask

    // monitor / scoreboard, sampled on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            model_cnt = 0;
            expq.delete();
        end else if (!done) begin
            bit acc_r, acc_w, rdy;
            logic [8:0] head;
            acc_r = rd_en && (model_cnt > 0);
            rdy   = (model_cnt < D) || acc_r;
            acc_w = wr_en && rdy;
            chk(wr_ready == rdy, "R3 ready", wr_ready, rdy);
            chk(rd_valid == (model_cnt > 0), "R4 valid", rd_valid, model_cnt > 0);
            chk(wr_half == (model_cnt >= D/2), "R6 wr_half", wr_half, model_cnt >= D/2);
            chk(rd_half == (model_cnt >= D/2), "R6 rd_half", rd_half, model_cnt >= D/2);
            if (model_cnt > 0) begin
                head = expq[0];
                chk({rd_marker, rd_byte} == head, "R4 R9 head", {rd_marker, rd_byte}, head);
                chk(rd_end_normal == (head == 9'h100), "R8 normal", rd_end_normal, head == 9'h100);
                chk(rd_end_error == (head == 9'h101), "R8 error", rd_end_error, head == 9'h101);
            end else begin
                chk(!rd_end_normal && !rd_end_error, "R8 idle", {rd_end_normal, rd_end_error}, 0);
            end
            if (acc_r) begin
                void'(expq.pop_front());
                model_cnt--;
            end
            if (acc_w) begin
                expq.push_back({wr_marker, wr_byte});
                model_cnt++;
            end
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(rd_valid == 0, "R1 valid", rd_valid, 0);
        chk(wr_ready == 1, "R1 ready", wr_ready, 1);
        chk(wr_half == 0 && rd_half == 0, "R1 half", {wr_half, rd_half}, 0);
        rst = 0;
        // R4 R8: a packet with normal end, then read
        cyc(1, 0, 8'h1c, 0);
        cyc(1, 0, 8'h0e, 0);
        cyc(1, 0, 8'h20, 0);
        cyc(1, 1, 8'h00, 0);
        cyc(0, 0, 8'h00, 0);
        repeat (4) cyc(0, 0, 8'h00, 1);
        // R5: read on empty
        repeat (2) cyc(0, 0, 8'h00, 1);
        // R8: error end and odd marked byte
        cyc(1, 1, 8'h01, 0);
        cyc(1, 1, 8'h05, 0);
        cyc(1, 0, 8'h01, 0);
        repeat (3) cyc(0, 0, 8'h00, 1);
        // R2 R3 R6: fill, overfill attempts
        for (int i = 0; i < D + 3; i++) cyc(1, 0, 8'(8'h40 + i), 0);
        // R7: simultaneous on full
        for (int i = 0; i < 3; i++) cyc(1, 0, 8'(8'h90 + i), 1);
        // drain
        for (int i = 0; i < D + 2; i++) cyc(0, 0, 8'h00, 1);
        // R9: streaming with mixed strobes and wrap
        lfsr = 16'hace1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[5], lfsr[3] & lfsr[7], lfsr[3] ? {7'd0, lfsr[9]} : lfsr[15:8],
                lfsr[2] & (lfsr[4] | i[6]));
        end
        for (int i = 0; i < D + 2; i++) cyc(0, 0, 8'h00, 1);
        cyc(0, 0, 8'h00, 0);
        // R1: reset again from a non-empty buffer
        cyc(1, 0, 8'h33, 0);
        cyc(1, 0, 8'h34, 0);
        cyc(0, 0, 8'h00, 0);
        rst = 1;
        @(posedge clk);
        #1;
        rst = 0;
        @(negedge clk);
        chk(rd_valid == 0, "R1 valid after reset", rd_valid, 0);
        chk(wr_ready == 1, "R1 ready after reset", wr_ready, 1);
        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule